// File: doc/BRIEF.md
# Reset-Time Strap Capture Controller

This block reads a 16-bit strap word while the synchronous system reset is held. It keeps the value sampled at the last reset clock edge and derives three settings from it. The first is a passive flag. When set, the chip is electrically withdrawn from the board: the pads float, the reset-out pin floats and the oscillator is stopped, so another device can drive the board. The second is the CPU clock multiplier. The third is the starting external bus type.

After reset, software can replace the bus-type field through a one-cycle write strobe. The passive state cannot be left through any write. Only a new reset in which the passive strap bit reads high clears it.

Top module: `strap_cfg_ctrl`

## Requirements
- R1: While `rst_n` is low, the strap word is sampled on every clock edge. The value present at the last edge with `rst_n` low is kept, and later changes on `strap_i` have no effect on any output until the next reset.
- R2: `passive_o` is 1 exactly when strap bit 1 was captured low. With bit 1 high, which is the default, the block is active.
- R3: While `passive_o` is 1, `pad_oe_o` is all zeros, `rst_out_oe_o` is 0 and `osc_en_o` is 0.
- R4: Once passive, the block stays passive through any strap change and any bus-type write. Only a reset with strap bit 1 high makes it active again.
- R5: Strap bits 15:13 select the clock ratio. `clk_mult_x2_o` gives twice the ratio: code 0 gives 1, code 1 gives 2, code 2 gives 4, code 3 gives 5, code 4 gives 6, code 5 gives 8 and code 6 gives 10.
- R6: The unused clock code 7 falls back to a 1x ratio, so `clk_mult_x2_o` is 2.
- R7: After reset, `bus_type_o` equals strap bits 7:6. Bit 1 of the field is the data-width select and bit 0 is the multiplexed/demultiplexed select.
- R8: A write (`bt_wr_en_i` high) on any clock edge after the first edge following reset release loads `bt_wr_data_i` into `bus_type_o` on that edge.
- R9: A write presented on the first edge with `rst_n` high is ignored, and the captured strap value stays in place.
- R10: When active and out of reset, `pad_oe_o` equals `core_oe_i`, `rst_out_o` is 1 and `rst_out_oe_o` is 1.
- R11: During reset, and on the release edge, `pad_oe_o` is all zeros and `rst_out_o` is 0. In that time `rst_out_oe_o` is 1 only when the sampled bit 1 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| strap_i | input | 16 | Configuration strap word |
| core_oe_i | input | 8 | Pad output enables requested by the core |
| bt_wr_en_i | input | 1 | Bus-type write strobe |
| bt_wr_data_i | input | 2 | Bus-type write value |
| passive_o | output | 1 | Passive (board-release) mode flag |
| clk_mult_x2_o | output | 4 | Clock multiplier times two |
| bus_type_o | output | 2 | Current bus-type field |
| pad_oe_o | output | 8 | Gated pad output enables |
| rst_out_o | output | 1 | Reset-out pin value (low while in reset) |
| rst_out_oe_o | output | 1 | Reset-out pin drive enable |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The bench walks through every clock code, including the unused eighth code. A decoder that left code 7 unmapped would report 0 or a random ratio instead of 1x. It changes the straps after release; a sampler that kept tracking them would switch mode with no reset. It issues a bus-type write on the release edge; a write port enabled one cycle too early would overwrite the strap value. It also enters passive mode and tries to leave it by strap change and by write. A design that let passive mode end without a reset, or that left the pads, the reset-out drive or the oscillator enabled while passive, would be caught at the pins.

// File: rtl/strap_cfg_pkg.sv
// Shared types for the strap capture controller.
// Assumes clock ratios are expressed as twice the multiplier to stay integral.
package strap_cfg_pkg;
    typedef enum logic [2:0] {
        RAT_0P5 = 3'd0,
        RAT_1   = 3'd1,
        RAT_2   = 3'd2,
        RAT_2P5 = 3'd3,
        RAT_3   = 3'd4,
        RAT_4   = 3'd5,
        RAT_5   = 3'd6
    } clk_ratio_e;

    // Twice the multiplier for a ratio, so 0.5x and 2.5x fit in an integer.
    function automatic logic [3:0] ratio_to_x2(clk_ratio_e r);
        case (r)
            RAT_0P5: return 4'd1;
            RAT_1:   return 4'd2;
            RAT_2:   return 4'd4;
            RAT_2P5: return 4'd5;
            RAT_3:   return 4'd6;
            RAT_4:   return 4'd8;
            RAT_5:   return 4'd10;
            default: return 4'd2;
        endcase
    endfunction
endpackage

// File: rtl/strap_sampler.sv
// Captures the strap word on every edge while reset is low, then holds it.
// Also provides run_o, which goes high one edge after reset is released.
// Assumes rst_n is synchronous to clk.
module strap_sampler #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] strap_i,
    output logic [CFG_W-1:0] cap_o,
    output logic             run_o
);
    logic [CFG_W-1:0] cap_q;
    logic             run_q;

    // Follow the straps during reset and freeze them once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= strap_i;
    end

    // Mark the cycles after the release edge.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assign cap_o = cap_q;
    assign run_o = run_q;

    // R1: the captured word cannot move once out of reset
    a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(cap_q));
endmodule

// File: rtl/clk_sel_decode.sv
// Maps the 3-bit clock-select strap code to a ratio and reports it as 2x multiplier.
// Assumes the code is stable outside reset (it comes from the sampler).
module clk_sel_decode
    import strap_cfg_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [3:0]        mult_x2_o
);
    clk_ratio_e ratio;

    // Pick a ratio for each code; the unused top code falls back to 1x.
    always_comb begin
        case (code_i)
            3'd0:    ratio = RAT_0P5;
            3'd1:    ratio = RAT_1;
            3'd2:    ratio = RAT_2;
            3'd3:    ratio = RAT_2P5;
            3'd4:    ratio = RAT_3;
            3'd5:    ratio = RAT_4;
            3'd6:    ratio = RAT_5;
            default: ratio = RAT_1;
        endcase
    end

    assign mult_x2_o = ratio_to_x2(ratio);
endmodule

// File: rtl/bus_type_reg.sv
// Holds the bus-type field. It is loaded from the straps during reset and
// software may write it afterwards. Writes are ignored until run_i is high,
// which drops any write on the release edge.
module bus_type_reg #(
    parameter int BT_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [BT_W-1:0] strap_bt_i,
    input  logic [BT_W-1:0] init_i,
    input  logic            wr_en_i,
    input  logic [BT_W-1:0] wr_data_i,
    output logic [BT_W-1:0] bt_o
);
    logic [BT_W-1:0] bt_q;

    // Load from the straps during reset; take software writes only once running.
    always_ff @(posedge clk) begin
        if (!rst_n)                bt_q <= strap_bt_i;
        else if (run_i && wr_en_i) bt_q <= wr_data_i;
    end

    assign bt_o = bt_q;

    // R9: on the release edge the field keeps the captured strap value
    a_r9_release_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> bt_q == $past(init_i));
    // R8: a write after the release edge is taken
    a_r8_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wr_en_i) |=> bt_q == $past(wr_data_i));
endmodule

// File: rtl/pad_gate.sv
// Pad, reset-out and oscillator control.
// Passive mode or reset floats the pads. Passive mode also floats reset-out
// and stops the oscillator.
module pad_gate #(
    parameter int PAD_W = 8
) (
    input  logic             run_i,
    input  logic             passive_i,
    input  logic [PAD_W-1:0] core_oe_i,
    output logic [PAD_W-1:0] pad_oe_o,
    output logic             rst_out_o,
    output logic             rst_out_oe_o,
    output logic             osc_en_o
);
    // Gate each pad enable individually.
    for (genvar i = 0; i < PAD_W; i++) begin : g_pad
        assign pad_oe_o[i] = core_oe_i[i] & run_i & ~passive_i;
    end

    // Reset-out is driven low during reset and floats when passive.
    always_comb begin
        rst_out_o    = run_i;
        rst_out_oe_o = ~passive_i;
        osc_en_o     = ~passive_i;
    end
endmodule

// File: rtl/strap_cfg_ctrl.sv
// Top level of the strap capture controller. It ties the sampler, clock decode,
// bus-type register and pad gating together.
// Assumes a synchronous active-low reset held for at least one clock edge.
module strap_cfg_ctrl #(
    parameter int CFG_W     = 16,
    parameter int PAD_W     = 8,
    parameter int ADAPT_BIT = 1,
    parameter int CLK_LSB   = 13,
    parameter int BT_LSB    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] strap_i,
    input  logic [PAD_W-1:0] core_oe_i,
    input  logic             bt_wr_en_i,
    input  logic [1:0]       bt_wr_data_i,
    output logic             passive_o,
    output logic [3:0]       clk_mult_x2_o,
    output logic [1:0]       bus_type_o,
    output logic [PAD_W-1:0] pad_oe_o,
    output logic             rst_out_o,
    output logic             rst_out_oe_o,
    output logic             osc_en_o
);
    localparam int CODE_W = 3;
    localparam int BT_W   = 2;

    logic [CFG_W-1:0] cap;
    logic             run;
    logic             passive;

    strap_sampler #(.CFG_W(CFG_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .cap_o(cap), .run_o(run)
    );

    assign passive = ~cap[ADAPT_BIT];

    clk_sel_decode #(.CODE_W(CODE_W)) u_dec (
        .code_i(cap[CLK_LSB +: CODE_W]), .mult_x2_o(clk_mult_x2_o)
    );

    bus_type_reg #(.BT_W(BT_W)) u_bt (
        .clk(clk), .rst_n(rst_n), .run_i(run),
        .strap_bt_i(strap_i[BT_LSB +: BT_W]), .init_i(cap[BT_LSB +: BT_W]),
        .wr_en_i(bt_wr_en_i), .wr_data_i(bt_wr_data_i), .bt_o(bus_type_o)
    );

    pad_gate #(.PAD_W(PAD_W)) u_pad (
        .run_i(run), .passive_i(passive), .core_oe_i(core_oe_i),
        .pad_oe_o(pad_oe_o), .rst_out_o(rst_out_o),
        .rst_out_oe_o(rst_out_oe_o), .osc_en_o(osc_en_o)
    );

    assign passive_o = passive;

    // R3: passive mode stops the oscillator and floats reset-out
    a_r3_passive_release: assert property (@(posedge clk) disable iff (!rst_n)
        passive_o |-> (!osc_en_o && !rst_out_oe_o));
    // R3, R11: pads float in passive mode and before the release edge
    a_r11_pads_float: assert property (@(posedge clk) disable iff (!rst_n)
        (passive_o || !rst_out_o) |-> pad_oe_o == '0);
    // R4: passive mode cannot end while out of reset
    a_r4_passive_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (run && passive_o) |=> passive_o);
endmodule

// File: tb/tb_strap_cfg_ctrl.sv
module tb_strap_cfg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] strap = 16'hFFFF;
    logic [7:0]  core_oe = 8'hA5;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_data = 2'b00;
    logic        passive;
    logic [3:0]  mult;
    logic [1:0]  bt;
    logic [7:0]  pad_oe;
    logic        rout, rout_oe, osc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    strap_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap), .core_oe_i(core_oe),
        .bt_wr_en_i(wr_en), .bt_wr_data_i(wr_data), .passive_o(passive),
        .clk_mult_x2_o(mult), .bus_type_o(bt), .pad_oe_o(pad_oe),
        .rst_out_o(rout), .rst_out_oe_o(rout_oe), .osc_en_o(osc)
    );

    // {strap, passive, mult_x2, bus_type}
    localparam int NV = 9;
    localparam logic [22:0] VEC [NV] = '{
        {16'hFFFF, 1'b0, 4'd2,  2'b11},
        {16'h0042, 1'b0, 4'd1,  2'b01},
        {16'h2080, 1'b1, 4'd2,  2'b10},
        {16'h40C2, 1'b0, 4'd4,  2'b11},
        {16'h6002, 1'b0, 4'd5,  2'b00},
        {16'h8040, 1'b1, 4'd6,  2'b01},
        {16'hA0C2, 1'b0, 4'd8,  2'b11},
        {16'hC002, 1'b0, 4'd10, 2'b00},
        {16'hE082, 1'b0, 4'd2,  2'b10}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Hold reset for three edges with the given straps, then release.
    task automatic do_reset(input logic [15:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: state during reset with default straps
        repeat (3) @(negedge clk);
        chk("R11 pads in reset", 16'(pad_oe), 16'h0);
        chk("R11 rst_out low", 16'(rout), 16'h0);
        chk("R11 rst_out driven", 16'(rout_oe), 16'h1);
        chk("R2 default active", 16'(passive), 16'h0);

        // R2 R5 R6 R7 R10 R3: table walk
        for (int i = 0; i < NV; i++) begin
            logic [15:0] s;
            logic        p;
            logic [3:0]  m;
            logic [1:0]  b;
            {s, p, m, b} = VEC[i];
            do_reset(s);
            chk("R2 passive flag", 16'(passive), 16'(p));
            chk(s[15:13] == 3'd7 ? "R6 fallback mult" : "R5 mult", 16'(mult), 16'(m));
            chk("R7 bus type", 16'(bt), 16'(b));
            chk(p ? "R3 pads" : "R10 pads", 16'(pad_oe), p ? 16'h0 : 16'hA5);
            chk(p ? "R3 osc" : "R10 osc", 16'(osc), 16'(!p));
            chk(p ? "R3 rst_out_oe" : "R10 rst_out_oe", 16'(rout_oe), 16'(!p));
            chk("R10 rst_out high", 16'(rout), 16'h1);
        end

        // R1: strap changes after release are ignored
        do_reset(16'h40C2);
        strap = 16'hE040;
        repeat (3) @(negedge clk);
        chk("R1 mult frozen", 16'(mult), 16'd4);
        chk("R1 passive frozen", 16'(passive), 16'h0);
        chk("R1 bus type frozen", 16'(bt), 16'(2'b11));

        // R1: the last reset-edge value wins
        @(negedge clk);
        rst_n = 1'b0;
        strap = 16'h0002;
        @(negedge clk);
        strap = 16'hC0C2;
        @(negedge clk);
        rst_n = 1'b1;
        strap = 16'h0000;
        @(negedge clk);
        chk("R1 last sample mult", 16'(mult), 16'd10);
        chk("R1 last sample bt", 16'(bt), 16'(2'b11));

        // R9: write on the release edge ignored
        @(negedge clk);
        rst_n = 1'b0;
        strap = 16'h0082;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        wr_en = 1'b1;
        wr_data = 2'b01;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 release write ignored", 16'(bt), 16'(2'b10));
        chk("R11 rst_out after release", 16'(rout), 16'h1);

        // R8: later write accepted
        wr_en = 1'b1;
        wr_data = 2'b01;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 write taken", 16'(bt), 16'(2'b01));
        wr_en = 1'b1;
        wr_data = 2'b11;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 second write", 16'(bt), 16'(2'b11));

        // R11: passive straps during reset
        @(negedge clk);
        rst_n = 1'b0;
        strap = 16'hFFFD;
        repeat (2) @(negedge clk);
        chk("R11 rst_out_oe passive in reset", 16'(rout_oe), 16'h0);
        chk("R11 pads passive in reset", 16'(pad_oe), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: passive survives strap change and writes
        strap = 16'hFFFF;
        wr_en = 1'b1;
        wr_data = 2'b00;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        chk("R4 still passive", 16'(passive), 16'h1);
        chk("R4 osc still off", 16'(osc), 16'h0);
        chk("R4 pads still float", 16'(pad_oe), 16'h0);
        do_reset(16'hFFFF);
        chk("R4 reset exits passive", 16'(passive), 16'h0);
        chk("R4 osc on again", 16'(osc), 16'h1);
        chk("R10 pads follow core", 16'(pad_oe), 16'hA5);
        core_oe = 8'h3C;
        #1;
        chk("R10 pads follow change", 16'(pad_oe), 16'h3C);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule